// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter sits on the receive byte stream of an Ethernet port and watches only the twelve address bytes at the head of each frame. Bytes 0 to 5 form the destination address and bytes 6 to 11 the source address. Once the last source byte has arrived, the block gives a one-cycle accept or drop verdict. A downstream frame store uses that verdict to keep or discard the frame. Payload bytes, frame check sequence validation and buffering are handled elsewhere.

The verdict depends on several settings: a 48-bit station address, a 64-bit multicast hash table and a configuration register. Each of them is written and read back through a simple 16-bit register port. Unicast frames need an exact station-address match. Broadcast frames always pass. A multicast frame passes through the hash table: the top six bits of a reflected CRC-32 over the destination address select one table bit. An all-multicast mode lets every multicast frame through. A promiscuous mode lets every frame through. A reject-own-source option drops frames that carry the station's own source address.

The receiver enable is read back as the value in force. That value follows a new write only between address headers, so software can clear the enable and poll until it reads zero before changing the filter. The header parser is a five-state machine:

- IDLE is the state after reset.
- DEST collects the destination bytes.
- SRC collects the source bytes.
- DECIDE is the single verdict cycle.
- WAIT skips the payload.

Its transitions are:

- A start byte moves the machine from IDLE or WAIT to DEST. From DEST, SRC or DECIDE, a start byte restarts DEST.
- DEST moves to SRC on byte 5.
- SRC moves to DECIDE on byte 11.
- DECIDE moves to WAIT when no start byte is present.

Top module: `rxaf_filter`

## Requirements
- R1: After reset every register reads 0, the enable in force is 0 and `frame_decided` is low.
- R2: Register map.
  - Addresses 0 to 2 hold the station address words. Word k carries address byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, and byte 0 is the first byte on the wire.
  - Addresses 3 to 6 hold hash words 0 to 3.
  - Address 7 is the configuration register: bit 0 receiver enable, bit 1 promiscuous, bit 2 hash-filter enable, bit 3 reject-own-source, bit 4 CRC enable, bit 5 all-multicast. The CRC enable bit is stored and read back and has no effect on the verdict.
  - Bits 15:6 of address 7 read 0, and unused addresses read 0.
- R3: A byte taken with `rx_valid` and `rx_sof` both high is byte 0 of a header. The following bytes taken while `rx_valid` is high fill bytes 1 to 11, and idle cycles in between are skipped. Bytes that arrive outside a header produce no verdict.
- R4: `frame_decided` is high for exactly one cycle: the cycle that follows the clock edge taking byte 11.
- R5: A start byte in the middle of a header discards the partial header and begins a new one.
- R6: When the enable in force is 0, every verdict is a drop.
- R7: The enable in force takes the written bit 0 at each clock edge where no header is in progress. A header is in progress from the edge after its start byte up to the edge taking byte 11. Between those edges the enable in force holds its value, and address 7 bit 0 reads it back.
- R8: A unicast frame (destination byte 0 bit 0 clear) is accepted only when all 48 destination bits equal the station address.
- R9: A broadcast frame (destination all ones) is accepted whenever the enable in force is 1, unless R13 drops it.
- R10: A multicast frame (destination byte 0 bit 0 set, not broadcast) is accepted when hash-filter enable is set and the selected table bit is 1.
  - The CRC starts at all ones, uses polynomial 0xEDB88320 in reflected form, shifts each byte in least significant bit first over bytes 0 to 5, and ends with no final inversion.
  - The index is CRC bits 31:26. Index bits 5:4 pick the hash word and bits 3:0 the bit within it.
- R11: With all-multicast set, every multicast frame is accepted while hash-filter enable is set, whatever the table holds.
- R12: With promiscuous set, every frame is accepted, subject to R6 and R13.
- R13: With reject-own-source set, a frame whose source address equals the station address is dropped, with priority over every other rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| frame_decided | output | 1 | Verdict cycle for the current header |
| frame_accept | output | 1 | Verdict: 1 accept, 0 drop, valid with `frame_decided` |

## Verification
The bench builds the block with its default parameters: 6-byte addresses, 16-bit registers and a 64-entry hash table held in four words. With these values, the index split over word and bit can be probed at real CRC results of real multicast addresses. The reference model computes the CRC bit by bit from the requirement and predicts every verdict and every read-back value each cycle. Directed frames cover the following cases:

- stalls in the middle of a header
- a restart in the middle of a header
- clearing the enable in the middle of a frame
- reject-own-source combined with promiscuous mode

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int RXAF_BYTE_W     = 8;
    localparam int RXAF_MAC_BYTES  = 6;
    localparam int RXAF_REG_W      = 16;
    localparam int RXAF_RADDR_W    = 4;
    localparam int RXAF_HASH_IDX_W = 6;
    localparam int RXAF_HASH_BITS  = 1 << RXAF_HASH_IDX_W;
    localparam int RXAF_CRC_W      = 32;
    localparam logic [RXAF_CRC_W-1:0] RXAF_CRC_POLY = 32'hEDB8_8320;
    localparam logic [RXAF_CRC_W-1:0] RXAF_CRC_INIT = '1;

    // configuration register bit positions
    localparam int CFG_EN        = 0;
    localparam int CFG_PROMISC   = 1;
    localparam int CFG_HASH_EN   = 2;
    localparam int CFG_REJECT    = 3;
    localparam int CFG_CRC_EN    = 4;
    localparam int CFG_ALLMULTI  = 5;
    localparam int CFG_BITS      = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEST,
        ST_SRC,
        ST_DECIDE,
        ST_WAIT
    } hdr_state_e;

    // one byte of reflected CRC-32, least significant bit first
    function automatic logic [RXAF_CRC_W-1:0] crc_step_byte(
        input logic [RXAF_CRC_W-1:0]  c_in,
        input logic [RXAF_BYTE_W-1:0] b
    );
        logic [RXAF_CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < RXAF_BYTE_W; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ RXAF_CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int REG_W     = RXAF_REG_W,
    parameter int RADDR_W   = RXAF_RADDR_W,
    parameter int MAC_BYTES = RXAF_MAC_BYTES,
    parameter int BYTE_W    = RXAF_BYTE_W,
    parameter int HASH_BITS = RXAF_HASH_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [RADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]              wdata,
    output logic [REG_W-1:0]              rdata,
    input  logic                          hdr_busy,
    output logic [MAC_BYTES*BYTE_W-1:0]   station,
    output logic [HASH_BITS-1:0]          hash_tab,
    output logic                          rx_en_eff,
    output logic                          promisc,
    output logic                          hash_en,
    output logic                          reject_own,
    output logic                          allmulti
);

    localparam int STA_WORDS  = MAC_BYTES * BYTE_W / REG_W;
    localparam int HASH_WORDS = HASH_BITS / REG_W;
    localparam int HASH_BASE  = STA_WORDS;
    localparam int CFG_ADDR   = HASH_BASE + HASH_WORDS;

    logic [CFG_BITS-1:0] cfg_q;
    logic                en_eff_q;

    // station address words
    for (genvar k = 0; k < STA_WORDS; k++) begin : g_sta
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && addr == RADDR_W'(k))
                word_q <= wdata;
        end
        assign station[k*REG_W +: REG_W] = word_q;
    end

    // multicast hash table words
    for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && addr == RADDR_W'(HASH_BASE + k))
                word_q <= wdata;
        end
        assign hash_tab[k*REG_W +: REG_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && addr == RADDR_W'(CFG_ADDR))
            cfg_q <= wdata[CFG_BITS-1:0];
    end

    // enable in force only moves between headers
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_eff_q <= 1'b0;
        else if (!hdr_busy)
            en_eff_q <= cfg_q[CFG_EN];
    end

    assign rx_en_eff  = en_eff_q;
    assign promisc    = cfg_q[CFG_PROMISC];
    assign hash_en    = cfg_q[CFG_HASH_EN];
    assign reject_own = cfg_q[CFG_REJECT];
    assign allmulti   = cfg_q[CFG_ALLMULTI];

    always_comb begin
        rdata = '0;
        for (int k = 0; k < STA_WORDS; k++)
            if (addr == RADDR_W'(k))
                rdata = station[k*REG_W +: REG_W];
        for (int k = 0; k < HASH_WORDS; k++)
            if (addr == RADDR_W'(HASH_BASE + k))
                rdata = hash_tab[k*REG_W +: REG_W];
        if (addr == RADDR_W'(CFG_ADDR))
            rdata = REG_W'({cfg_q[CFG_BITS-1:1], en_eff_q});
    end

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
#(
    parameter int CRC_W  = RXAF_CRC_W,
    parameter int BYTE_W = RXAF_BYTE_W,
    parameter int IDX_W  = RXAF_HASH_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [IDX_W-1:0]  idx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = restart ? RXAF_CRC_INIT : crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= RXAF_CRC_INIT;
        else if (step)
            crc_q <= crc_step_byte(crc_base, byte_in);
    end

    assign idx = crc_q[CRC_W-1 -: IDX_W];

endmodule

// File: rtl/rxaf_parser.sv
module rxaf_parser
    import rxaf_pkg::*;
#(
    parameter int MAC_BYTES = RXAF_MAC_BYTES,
    parameter int BYTE_W    = RXAF_BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic                        rx_sof,
    input  logic [BYTE_W-1:0]           rx_data,
    output logic [MAC_BYTES*BYTE_W-1:0] dest_addr,
    output logic [MAC_BYTES*BYTE_W-1:0] src_addr,
    output logic                        crc_step,
    output logic                        crc_restart,
    output logic                        hdr_busy,
    output logic                        decide
);

    localparam int HDR_BYTES = 2 * MAC_BYTES;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(HDR_BYTES);
    localparam logic [CNT_W-1:0] DEST_LAST = CNT_W'(MAC_BYTES - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);

    hdr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [HDR_W-1:0] hdr_q;
    logic             take_sof;
    logic             in_hdr;

    assign take_sof = rx_valid && rx_sof;
    assign in_hdr   = (state_q == ST_DEST) || (state_q == ST_SRC);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                if (take_sof) state_d = ST_DEST;
            end
            ST_DEST: begin
                if (take_sof)                            state_d = ST_DEST;
                else if (rx_valid && cnt_q == DEST_LAST) state_d = ST_SRC;
            end
            ST_SRC: begin
                if (take_sof)                           state_d = ST_DEST;
                else if (rx_valid && cnt_q == HDR_LAST) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                state_d = take_sof ? ST_DEST : ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // header byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hdr_q <= '0;
        end else if (take_sof) begin
            cnt_q                <= CNT_W'(1);
            hdr_q[BYTE_W-1:0]    <= rx_data;
        end else if (in_hdr && rx_valid) begin
            hdr_q[cnt_q*BYTE_W +: BYTE_W] <= rx_data;
            cnt_q <= (cnt_q == HDR_LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        hdr_busy    = in_hdr;
        decide      = (state_q == ST_DECIDE);
        crc_restart = take_sof;
        crc_step    = take_sof || ((state_q == ST_DEST) && rx_valid);
    end

    assign dest_addr = hdr_q[MAC_BYTES*BYTE_W-1:0];
    assign src_addr  = hdr_q[HDR_W-1:MAC_BYTES*BYTE_W];

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int ADDR_W    = RXAF_MAC_BYTES * RXAF_BYTE_W,
    parameter int HASH_BITS = RXAF_HASH_BITS,
    parameter int IDX_W     = RXAF_HASH_IDX_W
) (
    input  logic                 en_eff,
    input  logic                 promisc,
    input  logic                 hash_en,
    input  logic                 reject_own,
    input  logic                 allmulti,
    input  logic [ADDR_W-1:0]    station,
    input  logic [HASH_BITS-1:0] hash_tab,
    input  logic [ADDR_W-1:0]    dest_addr,
    input  logic [ADDR_W-1:0]    src_addr,
    input  logic [IDX_W-1:0]     hash_idx,
    output logic                 accept
);

    logic own_src, is_bcast, is_mcast, hash_hit;

    always_comb begin
        own_src  = reject_own && (src_addr == station);
        is_bcast = &dest_addr;
        is_mcast = dest_addr[0];
        hash_hit = hash_tab[hash_idx];

        if (!en_eff || own_src)  accept = 1'b0;
        else if (promisc)        accept = 1'b1;
        else if (is_bcast)       accept = 1'b1;
        else if (is_mcast)       accept = hash_en && (allmulti || hash_hit);
        else                     accept = (dest_addr == station);
    end

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
    import rxaf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_data,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        frame_decided,
    output logic        frame_accept
);

    localparam int ADDR_W = RXAF_MAC_BYTES * RXAF_BYTE_W;

    logic [ADDR_W-1:0]         station, dest_addr, src_addr;
    logic [RXAF_HASH_BITS-1:0] hash_tab;
    logic [RXAF_HASH_IDX_W-1:0] hash_idx;
    logic rx_en_eff, promisc, hash_en, reject_own, allmulti;
    logic hdr_busy, crc_step, crc_restart, decide;

    rxaf_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .hdr_busy   (hdr_busy),
        .station    (station),
        .hash_tab   (hash_tab),
        .rx_en_eff  (rx_en_eff),
        .promisc    (promisc),
        .hash_en    (hash_en),
        .reject_own (reject_own),
        .allmulti   (allmulti)
    );

    rxaf_parser u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_data     (rx_data),
        .dest_addr   (dest_addr),
        .src_addr    (src_addr),
        .crc_step    (crc_step),
        .crc_restart (crc_restart),
        .hdr_busy    (hdr_busy),
        .decide      (decide)
    );

    rxaf_hash u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (crc_step),
        .restart (crc_restart),
        .byte_in (rx_data),
        .idx     (hash_idx)
    );

    rxaf_decide u_decide (
        .en_eff     (rx_en_eff),
        .promisc    (promisc),
        .hash_en    (hash_en),
        .reject_own (reject_own),
        .allmulti   (allmulti),
        .station    (station),
        .hash_tab   (hash_tab),
        .dest_addr  (dest_addr),
        .src_addr   (src_addr),
        .hash_idx   (hash_idx),
        .accept     (frame_accept)
    );

    assign frame_decided = decide;

endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_decided,
    input logic              frame_accept,
    input logic              hdr_busy,
    input logic              en_eff,
    input logic              promisc,
    input logic              reject_own,
    input logic [ADDR_W-1:0] dest_addr,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] station
);

    AST_SINGLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided |=> !frame_decided); // R4

    AST_VERDICT_AFTER_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided |-> $past(hdr_busy)); // R3

    AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided && !en_eff |-> !frame_accept); // R6

    AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_busy |=> $stable(en_eff)); // R7

    AST_BCAST_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided && en_eff && (&dest_addr) && !(reject_own && src_addr == station)
        |-> frame_accept); // R9

    AST_PROMISC_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided && en_eff && promisc && !(reject_own && src_addr == station)
        |-> frame_accept); // R12

    AST_OWN_SOURCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_decided && reject_own && src_addr == station |-> !frame_accept); // R13

endmodule

bind rxaf_filter rxaf_filter_chk #(.ADDR_W(48)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_decided (frame_decided),
    .frame_accept  (frame_accept),
    .hdr_busy      (hdr_busy),
    .en_eff        (rx_en_eff),
    .promisc       (promisc),
    .reject_own    (reject_own),
    .dest_addr     (dest_addr),
    .src_addr      (src_addr),
    .station       (station)
);

// File: tb/rxaf_filter_test.sv
module rxaf_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        frame_decided, frame_accept;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 0;

    always #2 clk = ~clk;

    rxaf_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_decided(frame_decided), .frame_accept(frame_accept)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_sta [3];
    logic [15:0] m_hash [4];
    logic [5:0]  m_cfg;
    bit          m_en;
    int          m_cnt;
    logic [95:0] m_hdr;
    bit          m_dec, m_acc;

    function automatic logic [31:0] ref_crc(input logic [47:0] d);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 8; j++) begin
                logic fb = c[0] ^ d[8*i+j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        return c;
    endfunction

    function automatic bit ref_accept();
        logic [47:0] d   = m_hdr[47:0];
        logic [47:0] s   = m_hdr[95:48];
        logic [47:0] sta = {m_sta[2], m_sta[1], m_sta[0]};
        logic [5:0]  ix;
        if (!m_en) return 0;
        if (m_cfg[3] && s == sta) return 0;
        if (m_cfg[1]) return 1;
        if (&d) return 1;
        if (d[0]) begin
            if (!m_cfg[2]) return 0;
            if (m_cfg[5]) return 1;
            ix = ref_crc(d) >> 26;
            return m_hash[ix[5:4]][ix[3:0]];
        end
        return d == sta;
    endfunction

    function automatic logic [15:0] ref_rdata(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2:        return m_sta[a];
            4'd3, 4'd4, 4'd5, 4'd6:  return m_hash[a - 4'd3];
            4'd7:                    return {10'b0, m_cfg[5:1], m_en};
            default:                 return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit busy;
        if (!rst_n) begin
            foreach (m_sta[i])  m_sta[i]  = '0;
            foreach (m_hash[i]) m_hash[i] = '0;
            m_cfg = '0; m_en = 0; m_cnt = 0; m_hdr = '0; m_dec = 0; m_acc = 0;
        end else begin
            busy = (m_cnt >= 1);
            if (!busy) m_en = m_cfg[0];
            if (reg_wr) begin
                if (reg_addr <= 4'd2)      m_sta[reg_addr] = reg_wdata;
                else if (reg_addr <= 4'd6) m_hash[reg_addr - 4'd3] = reg_wdata;
                else if (reg_addr == 4'd7) m_cfg = reg_wdata[5:0];
            end
            m_dec = 0;
            if (rx_valid) begin
                if (rx_sof) begin
                    m_hdr[7:0] = rx_data;
                    m_cnt = 1;
                end else if (busy) begin
                    m_hdr[8*m_cnt +: 8] = rx_data;
                    m_cnt++;
                    if (m_cnt == 12) begin
                        m_cnt = 0;
                        m_dec = 1;
                    end
                end
            end
            if (m_dec) m_acc = ref_accept();
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check({cur_req, " verdict strobe"}, 16'(frame_decided), 16'(m_dec));
            if (m_dec) check({cur_req, " verdict"}, 16'(frame_accept), 16'(m_acc));
            check({cur_req, " readback"}, reg_rdata, ref_rdata(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk); #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic frame(input string req, input logic [47:0] d, input logic [47:0] s,
                         input bit exp, input bit gap);
        logic [95:0] h = {s, d};
        cur_req = req;
        for (int i = 0; i < 12; i++) begin
            if (gap && (i == 3 || i == 7)) begin
                @(negedge clk);
                rx_valid = 0; rx_sof = 0;
            end
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_data = h[8*i +: 8];
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0;
        check({req, " decided"}, 16'(frame_decided), 16'd1);
        check({req, " accept"},  16'(frame_accept),  16'(exp));
        @(posedge clk); #1;
        check("R4 single pulse", 16'(frame_decided), 16'd0);
    endtask

    localparam logic [47:0] STA   = 48'hA5B4_C3D2_E1F0;
    localparam logic [47:0] OTHER = 48'h1122_3344_5566;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0000_5E00_0101;
    localparam logic [47:0] MCST2 = 48'h3300_0000_0133;

    initial begin : main
        logic [5:0] ix;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 8; a++) rd("R1 reset read", 4'(a), 16'h0);
        check("R1 no verdict", 16'(frame_decided), 16'd0);

        // R2 register map
        cur_req = "R2";
        wr(4'd0, STA[15:0]); wr(4'd1, STA[31:16]); wr(4'd2, STA[47:32]);
        rd("R2 station w0", 4'd0, 16'hE1F0);
        rd("R2 station w2", 4'd2, 16'hA5B4);
        wr(4'd5, 16'hBEEF);
        rd("R2 hash w2", 4'd5, 16'hBEEF);
        wr(4'd5, 16'h0000);
        wr(4'd7, 16'hFFC0 | 16'h0011);
        rd("R2 cfg upper bits zero, enable in force", 4'd7, 16'h0011);
        rd("R2 unused address", 4'd9, 16'h0);

        // R2 crc-enable bit has no effect; R8 unicast
        frame("R8 unicast match", STA, OTHER, 1, 0);
        wr(4'd7, 16'h0001);
        frame("R8 unicast one bit off", STA ^ 48'h0100_0000_0000, OTHER, 0, 0);
        frame("R3 header with stalls", STA, OTHER, 1, 1);

        // R3 bytes outside header ignored
        cur_req = "R3";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = 0; rx_data = 8'hFF;
        end
        @(negedge clk); rx_valid = 0;
        check("R3 no verdict outside header", 16'(frame_decided), 16'd0);

        // R9 broadcast
        frame("R9 broadcast", BCAST, OTHER, 1, 0);

        // R10 multicast hash
        wr(4'd7, 16'h0005);
        ix = ref_crc(MCAST) >> 26;
        wr(4'd3 + 4'(ix[5:4]), 16'h1 << ix[3:0]);
        frame("R10 multicast bit set", MCAST, OTHER, 1, 0);
        wr(4'd3 + 4'(ix[5:4]), ~(16'h1 << ix[3:0]));
        frame("R10 multicast bit clear", MCAST, OTHER, 0, 0);
        wr(4'd3 + 4'(ix[5:4]), 16'h1 << ix[3:0]);
        wr(4'd7, 16'h0001);
        frame("R10 hash filter disabled", MCAST, OTHER, 0, 0);
        wr(4'd7, 16'h0005);
        frame("R10 other multicast", MCST2, OTHER, ref_crc(MCST2) >> 26 == 32'(ix), 0);

        // R11 all-multicast
        wr(4'd7, 16'h0025);
        frame("R11 all multicast", MCST2, OTHER, 1, 0);

        // R12 promiscuous
        wr(4'd7, 16'h0003);
        frame("R12 promiscuous", OTHER, OTHER, 1, 0);

        // R13 reject own source
        wr(4'd7, 16'h000B);
        frame("R13 own source under promisc", BCAST, STA, 0, 0);
        frame("R13 other source", STA, OTHER, 1, 0);

        // R5 restart mid-header
        wr(4'd7, 16'h0001);
        cur_req = "R5";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_data = 8'h77;
        end
        frame("R5 restart", STA, OTHER, 1, 0);

        // R6 disabled
        wr(4'd7, 16'h0002);
        frame("R6 disabled drops", BCAST, OTHER, 0, 0);

        // R7 enable cleared mid-frame
        wr(4'd7, 16'h0001);
        cur_req = "R7";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 6) check("R7 enable held mid-header", reg_rdata, 16'h0001);
            rx_valid = 1; rx_sof = (i == 0); rx_data = 8'hFF;
            reg_wr = (i == 3); reg_addr = 4'd7; reg_wdata = 16'h0000;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; reg_wr = 0;
        check("R7 decided", 16'(frame_decided), 16'd1);
        check("R7 frozen enable accepts", 16'(frame_accept), 16'd1);
        @(negedge clk);
        check("R7 enable drops after header", reg_rdata, 16'h0000);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule